// File: doc/BRIEF.md
# Streaming Sobel Edge Pipeline

This block sits directly behind a camera port that delivers RGB 5:6:5 pixels as a byte stream, one byte for each cycle on which `byte_en` is high. It pairs the bytes into pixels and converts each pixel to an 8-bit luminance value. It keeps the two previous lines in a line buffer, so a 3x3 neighbourhood is available without a frame store. Two Sobel convolutions, one horizontal and one vertical, are combined into an edge strength. A mode input selects whether the 24-bit output carries the original colour video or the grey edge image.

Frame and line boundaries are marked by flags that accompany the first byte of a frame or of a line. Each input pixel at row r >= 1 and column c >= 1 yields one output pixel, for the image position (r-1, c-1). The output therefore trails the input by one line and one pixel, plus a fixed four-cycle register delay.

Top module: `sobel_edge_pipe`

## Requirements
- R1: Byte pairing and direct video. The first byte of a pixel carries R[4:0] in bits 7:3 and G[5:3] in bits 2:0. The second byte carries G[2:0] in bits 7:5 and B[4:0] in bits 4:0. In direct mode, `out_pix` is {R8, G8, B8} in bits 23:16, 15:8 and 7:0, where R8 = {R, R[4:2]}, G8 = {G, G[5:4]} and B8 = {B, B[4:2]}.
- R2: A byte that arrives with `line_start` or `frame_start` high is always taken as the first byte of a pixel. A lone byte left before it is discarded. Idle cycles between bytes do not change the result.
- R3: Bytes that arrive before the first `frame_start` after reset produce no output. Pixels beyond IMG_W in a line produce no output, and neither do lines beyond IMG_H in a frame.
- R4: Luminance is (R8*77 + G8*150 + B8*29) >> 8.
- R5: In edge mode, the value is |Gx|+|Gy| saturated to 255. Gx uses the kernel rows (-1 0 1), (-2 0 2), (-1 0 1) over the 3x3 luminance window, and Gy uses the transpose of that kernel. The value is replicated on all three 8-bit channels.
- R6: In edge mode, an output whose centre lies on row 0 or column 0 is zero.
- R7: Each accepted pixel at row r >= 1 and column c >= 1 gives exactly one output, for centre (r-1, c-1), in arrival order. A frame therefore yields (IMG_H-1)*(IMG_W-1) outputs. `out_valid` rises 4 cycles after the cycle that presented the completing byte, and it is never high on two consecutive cycles.
- R8: `edge_mode` = 1 selects the edge image and 0 selects direct video. The input is sampled on the cycle in which the output is registered.
- R9: While `rst` is high, `out_valid` and `out_pix` are cleared to zero on each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-side clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_en | input | 1 | Byte strobe for `byte_data` |
| byte_data | input | 8 | Camera byte, half of an RGB 5:6:5 pixel |
| frame_start | input | 1 | Marks the first byte of a frame (also a line start) |
| line_start | input | 1 | Marks the first byte of a line |
| edge_mode | input | 1 | 1 = edge image, 0 = direct video |
| out_valid | output | 1 | One-cycle strobe for `out_pix` |
| out_pix | output | 24 | Output pixel, R in 23:16, G in 15:8, B in 7:0 |

## Verification
The assertions take for granted that `frame_start` is only raised together with `byte_en` on the first byte of a line, and that `edge_mode` is a plain level that is only read at the output register. With those inputs, the latency, spacing and channel-replication properties hold for every output. The bench drives the sync flags only on the first byte of a line, changes `edge_mode` only between frames, and separates frames by idle gaps. The stray bytes, extra pixels and extra lines it injects stay inside that contract.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

  // luminance weights, scaled by 256
  localparam int LUMA_R = 77;
  localparam int LUMA_G = 150;
  localparam int LUMA_B = 29;

  // one line-buffer entry: colour of the row above, its luminance, and the luminance two rows up
  typedef struct packed {
    logic [15:0] rgb_up1;
    logic [7:0]  luma_up1;
    logic [7:0]  luma_up2;
  } lb_word_t;

  // widen 5:6:5 to 8:8:8 by repeating the top bits into the bottom
  function automatic logic [23:0] expand565(input logic [15:0] p);
    return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
  endfunction

  function automatic logic [7:0] luma8(input logic [23:0] c);
    logic [17:0] acc;
    acc = 18'(c[23:16]) * 18'(LUMA_R)
        + 18'(c[15:8])  * 18'(LUMA_G)
        + 18'(c[7:0])   * 18'(LUMA_B);
    return acc[15:8];
  endfunction

endpackage

// File: rtl/sobel_byte_pair.sv
module sobel_byte_pair #(
  parameter int IMG_W = 480,
  parameter int IMG_H = 272,
  parameter int COL_W = 9,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_en,
  input  logic [7:0]       byte_data,
  input  logic             frame_start,
  input  logic             line_start,
  output logic             px_v,
  output logic [15:0]      px_rgb,
  output logic [COL_W-1:0] px_col,
  output logic [ROW_W-1:0] px_row
);

  logic             phase_q;   // 1: waiting for the second byte
  logic [7:0]       hi_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             in_frame_q;
  logic             new_line;
  logic             col_ok;
  logic             row_ok;

  assign new_line = line_start | frame_start;
  assign col_ok   = col_q < COL_W'(IMG_W);
  assign row_ok   = row_q < ROW_W'(IMG_H);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= 1'b0;
      hi_q       <= '0;
      col_q      <= '0;
      row_q      <= '0;
      in_frame_q <= 1'b0;
      px_v       <= 1'b0;
      px_rgb     <= '0;
      px_col     <= '0;
      px_row     <= '0;
    end else begin
      px_v <= 1'b0;
      if (byte_en) begin
        if (frame_start) begin
          in_frame_q <= 1'b1;
          row_q      <= '0;
        end else if (line_start && row_ok) begin
          row_q <= row_q + 1'b1;
        end

        if (new_line || !phase_q) begin
          hi_q    <= byte_data;
          phase_q <= 1'b1;
          if (new_line) col_q <= '0;
        end else begin
          phase_q <= 1'b0;
          if (in_frame_q && col_ok && row_ok) begin
            px_v   <= 1'b1;
            px_rgb <= {hi_q, byte_data};
            px_col <= col_q;
            px_row <= row_q;
          end
          if (col_ok) col_q <= col_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sobel_line_window.sv
module sobel_line_window
  import sobel_pkg::*;
#(
  parameter int IMG_W = 480,
  parameter int COL_W = 9,
  parameter int ROW_W = 9,
  localparam int ADDR_W = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_v,
  input  logic [15:0]           in_rgb,
  input  logic [7:0]            in_luma,
  input  logic [COL_W-1:0]      in_col,
  input  logic [ROW_W-1:0]      in_row,
  output logic                  win_v,
  output logic [2:0][2:0][7:0]  win,      // [row][col], row 2 = newest line, col 2 = newest column
  output logic [15:0]           ctr_rgb,
  output logic [COL_W-1:0]      win_col,
  output logic [ROW_W-1:0]      win_row
);

  lb_word_t mem [IMG_W];
  lb_word_t rd_q;

  logic             s1_v;
  logic [15:0]      s1_rgb;
  logic [7:0]       s1_luma;
  logic [COL_W-1:0] s1_col;
  logic [ROW_W-1:0] s1_row;

  logic [2:0][7:0]      new_col;
  logic [2:0][2:0][7:0] win_q;
  logic [15:0]          rgb_right_q;
  logic [15:0]          rgb_ctr_q;

  // read port: one entry per pixel, registered
  always_ff @(posedge clk) begin
    if (in_v) rd_q <= mem[in_col[ADDR_W-1:0]];
  end

  // write port: one cycle later, the entry moves down one row
  always_ff @(posedge clk) begin
    if (s1_v) mem[s1_col[ADDR_W-1:0]] <= {s1_rgb, s1_luma, rd_q.luma_up1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_rgb  <= '0;
      s1_luma <= '0;
      s1_col  <= '0;
      s1_row  <= '0;
    end else begin
      s1_v <= in_v;
      if (in_v) begin
        s1_rgb  <= in_rgb;
        s1_luma <= in_luma;
        s1_col  <= in_col;
        s1_row  <= in_row;
      end
    end
  end

  assign new_col = {s1_luma, rd_q.luma_up1, rd_q.luma_up2};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_v   <= 1'b0;
      win_col <= '0;
      win_row <= '0;
    end else begin
      win_v <= s1_v;
      if (s1_v) begin
        win_col <= s1_col;
        win_row <= s1_row;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (s1_v) begin
      for (int r = 0; r < 3; r++) begin
        win_q[r][0] <= win_q[r][1];
        win_q[r][1] <= win_q[r][2];
        win_q[r][2] <= new_col[r];
      end
      rgb_right_q <= rd_q.rgb_up1;
      rgb_ctr_q   <= rgb_right_q;
    end
  end

  assign win     = win_q;
  assign ctr_rgb = rgb_ctr_q;

endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel #(
  parameter int PIX_W = 8,
  localparam int SUM_W = PIX_W + 4
) (
  input  logic [2:0][2:0][PIX_W-1:0] win,
  output logic [PIX_W-1:0]           mag
);

  logic signed [SUM_W-1:0] tap_x [9];
  logic signed [SUM_W-1:0] tap_y [9];
  logic signed [SUM_W-1:0] gx;
  logic signed [SUM_W-1:0] gy;
  logic        [SUM_W-1:0] ax;
  logic        [SUM_W-1:0] ay;
  logic        [SUM_W-1:0] total;

  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      localparam int KX = (c - 1) * ((r == 1) ? 2 : 1);
      localparam int KY = (r - 1) * ((c == 1) ? 2 : 1);
      localparam logic signed [SUM_W-1:0] KXS = SUM_W'(KX);
      localparam logic signed [SUM_W-1:0] KYS = SUM_W'(KY);
      logic signed [SUM_W-1:0] px_s;
      assign px_s             = $signed({{(SUM_W-PIX_W){1'b0}}, win[r][c]});
      assign tap_x[r*3 + c]   = px_s * KXS;
      assign tap_y[r*3 + c]   = px_s * KYS;
    end
  end

  always_comb begin
    gx = '0;
    gy = '0;
    for (int i = 0; i < 9; i++) begin
      gx = gx + tap_x[i];
      gy = gy + tap_y[i];
    end
    ax    = gx[SUM_W-1] ? -gx : gx;
    ay    = gy[SUM_W-1] ? -gy : gy;
    total = ax + ay;
    mag   = (total > SUM_W'((1 << PIX_W) - 1)) ? '1 : total[PIX_W-1:0];
  end

endmodule

// File: rtl/sobel_edge_pipe.sv
module sobel_edge_pipe
  import sobel_pkg::*;
#(
  parameter int IMG_W = 480,
  parameter int IMG_H = 272
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_en,
  input  logic [7:0]  byte_data,
  input  logic        frame_start,
  input  logic        line_start,
  input  logic        edge_mode,
  output logic        out_valid,
  output logic [23:0] out_pix
);

  localparam int COL_W = $clog2(IMG_W + 1);
  localparam int ROW_W = $clog2(IMG_H + 1);

  logic                 px_v;
  logic [15:0]          px_rgb;
  logic [COL_W-1:0]     px_col;
  logic [ROW_W-1:0]     px_row;
  logic [7:0]           px_luma;

  logic                 win_v;
  logic [2:0][2:0][7:0] win;
  logic [15:0]          ctr_rgb;
  logic [COL_W-1:0]     win_col;
  logic [ROW_W-1:0]     win_row;
  logic [7:0]           mag;

  logic                 emit;
  logic                 border;

  sobel_byte_pair #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) u_pair (
    .clk         (clk),
    .rst         (rst),
    .byte_en     (byte_en),
    .byte_data   (byte_data),
    .frame_start (frame_start),
    .line_start  (line_start),
    .px_v        (px_v),
    .px_rgb      (px_rgb),
    .px_col      (px_col),
    .px_row      (px_row)
  );

  assign px_luma = luma8(expand565(px_rgb));

  sobel_line_window #(
    .IMG_W (IMG_W),
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) u_window (
    .clk     (clk),
    .rst     (rst),
    .in_v    (px_v),
    .in_rgb  (px_rgb),
    .in_luma (px_luma),
    .in_col  (px_col),
    .in_row  (px_row),
    .win_v   (win_v),
    .win     (win),
    .ctr_rgb (ctr_rgb),
    .win_col (win_col),
    .win_row (win_row)
  );

  sobel_kernel #(
    .PIX_W (8)
  ) u_kernel (
    .win (win),
    .mag (mag)
  );

  // the centre sits one row up and one column left of the newest pixel
  assign emit   = win_v && (win_row != '0) && (win_col != '0);
  assign border = (win_row == ROW_W'(1)) || (win_col == COL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        if (edge_mode) out_pix <= border ? 24'd0 : {mag, mag, mag};
        else           out_pix <= expand565(ctr_rgb);
      end
    end
  end

endmodule

// File: rtl/sobel_edge_pipe_chk.sv
module sobel_edge_pipe_chk (
  input logic        clk,
  input logic        rst,
  input logic        byte_en,
  input logic        frame_start,
  input logic        edge_mode,
  input logic        out_valid,
  input logic [23:0] out_pix
);

  logic seen_frame_q;

  always_ff @(posedge clk) begin
    if (rst)                        seen_frame_q <= 1'b0;
    else if (byte_en && frame_start) seen_frame_q <= 1'b1;
  end

  // R9: reset clears the output register
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == 24'd0));

  // R3: nothing leaves before a frame has begun
  a_r3_quiet_before_frame: assert property (@(posedge clk) disable iff (rst)
    !seen_frame_q |-> !out_valid);

  // R7: fixed latency from the completing byte
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(byte_en, 4));

  // R7: outputs are never back to back
  a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5: edge output is grey
  a_r5_grey_edge: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(edge_mode)) |->
      (out_pix[23:16] == out_pix[15:8] && out_pix[15:8] == out_pix[7:0]));

  // R1: direct output low bits repeat the high bits
  a_r1_bit_replicate: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(edge_mode)) |->
      (out_pix[18:16] == out_pix[23:21] && out_pix[9:8] == out_pix[15:14] &&
       out_pix[2:0] == out_pix[7:5]));

endmodule

bind sobel_edge_pipe sobel_edge_pipe_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .byte_en     (byte_en),
  .frame_start (frame_start),
  .edge_mode   (edge_mode),
  .out_valid   (out_valid),
  .out_pix     (out_pix)
);

// File: tb/sobel_edge_pipe_bench.sv
`timescale 1ns/1ps
module sobel_edge_pipe_bench;

  localparam int W = 8;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_en = 1'b0;
  logic [7:0]  byte_data = 8'd0;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        edge_mode = 1'b0;
  logic        out_valid;
  logic [23:0] out_pix;

  sobel_edge_pipe #(.IMG_W(W), .IMG_H(H)) u_sobel_edge_pipe (
    .clk(clk), .rst(rst), .byte_en(byte_en), .byte_data(byte_data),
    .frame_start(frame_start), .line_start(line_start), .edge_mode(edge_mode),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [15:0] img [H][W];
  logic [23:0] exp_q [64];
  int          exp_n = 0;
  logic [23:0] act_q [64];
  int          act_cyc [64];
  int          act_n = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      if (act_n < 64) begin
        act_q[act_n]   = out_pix;
        act_cyc[act_n] = cyc;
      end
      act_n = act_n + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] m_expand(input logic [15:0] p);
    int r5, g6, b5;
    r5 = int'(p[15:11]); g6 = int'(p[10:5]); b5 = int'(p[4:0]);
    return {8'((r5 << 3) | (r5 >> 2)), 8'((g6 << 2) | (g6 >> 4)), 8'((b5 << 3) | (b5 >> 2))};
  endfunction

  function automatic int m_luma(input logic [15:0] p);
    logic [23:0] e;
    e = m_expand(p);
    return (int'(e[23:16]) * 77 + int'(e[15:8]) * 150 + int'(e[7:0]) * 29) / 256;
  endfunction

  function automatic int m_edge(input int y, input int x);
    int gx, gy, l, m;
    if (y == 0 || x == 0) return 0;
    gx = 0; gy = 0;
    for (int dy = -1; dy <= 1; dy++) begin
      for (int dx = -1; dx <= 1; dx++) begin
        l  = m_luma(img[y+dy][x+dx]);
        gx += dx * ((dy == 0) ? 2 : 1) * l;
        gy += dy * ((dx == 0) ? 2 : 1) * l;
      end
    end
    m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    return (m > 255) ? 255 : m;
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic fs, input logic ls, input bit gap, output int at);
    @(negedge clk);
    byte_en = 1'b1; byte_data = d; frame_start = fs; line_start = ls; at = cyc;
    if (gap) begin
      @(negedge clk);
      byte_en = 1'b0; frame_start = 1'b0; line_start = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      byte_en = 1'b0; frame_start = 1'b0; line_start = 1'b0;
    end
  endtask

  task automatic run_frame(input bit mode, input bit gap, input bit stray,
                           input int xpx, input int xln, input string tag);
    int at, mark, y, x;
    logic [15:0] p;
    string lbl;
    mark  = -1;
    exp_n = 0;
    for (int r = 1; r < H; r++)
      for (int c = 1; c < W; c++) begin
        exp_q[exp_n] = mode ? {3{8'(m_edge(r-1, c-1))}} : m_expand(img[r-1][c-1]);
        exp_n++;
      end
    @(negedge clk);
    act_n = 0;
    edge_mode = mode;
    for (int r = 0; r < H + xln; r++) begin
      if (stray) send_byte(8'h5A, 1'b0, 1'b0, gap, at);
      for (int c = 0; c < W + xpx; c++) begin
        p = (r < H && c < W) ? img[r][c] : (16'hC3A5 ^ 16'(c * 257 + r));
        send_byte(p[15:8], (r == 0 && c == 0), (c == 0), gap, at);
        send_byte(p[7:0], 1'b0, 1'b0, gap, at);
        if (r == 1 && c == 1) mark = at;
      end
    end
    idle(12);
    check({"R7 ", tag}, "output count", act_n, exp_n);
    for (int i = 0; i < exp_n && i < act_n && i < 64; i++) begin
      y = i / (W - 1);
      x = i % (W - 1);
      if (!mode)                lbl = {"R1,R8 ", tag};
      else if (y == 0 || x == 0) lbl = {"R6,R8 ", tag};
      else                      lbl = {"R4,R5 ", tag};
      check(lbl, $sformatf("centre (%0d,%0d)", y, x), int'(act_q[i]), int'(exp_q[i]));
    end
    if (act_n > 0) check({"R7 ", tag}, "latency", act_cyc[0] - mark, 4);
  endtask

  task automatic fill_random(input int f);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        img[y][x] = 16'((y * 7919 + x * 104729 + f * 31337) ^ (x * y * 977 + f));
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int at;
    repeat (3) @(negedge clk);
    check("R9", "out_valid in reset", int'(out_valid), 0);
    check("R9", "out_pix in reset", int'(out_pix), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R3: bytes before any frame start
    for (int k = 0; k < 6; k++) send_byte(8'(k * 17 + 3), 1'b0, (k == 0 || k == 3), 1'b0, at);
    idle(10);
    check("R3", "outputs before first frame", act_n, 0);

    fill_random(1);
    run_frame(1'b1, 1'b0, 1'b0, 0, 0, "edge random");

    fill_random(2);
    run_frame(1'b0, 1'b1, 1'b0, 0, 0, "R2 direct gaps");

    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        img[y][x] = (x + y >= 5) ? 16'hFFFF : 16'h0000;
    run_frame(1'b1, 1'b0, 1'b1, 0, 0, "R2 stray saturating");

    fill_random(4);
    run_frame(1'b1, 1'b0, 1'b0, 3, 2, "R3 extra pixels and lines");

    fill_random(5);
    run_frame(1'b0, 1'b1, 1'b1, 0, 0, "R2 R3 recovery");

    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        img[y][x] = 16'((x * 4) << 11 | (y * 9) << 5 | (x + y));
    run_frame(1'b1, 1'b0, 1'b0, 0, 0, "ramp");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule